// File: doc/BRIEF.md
# Descriptor RAM Load Port

This block holds the byte-wide descriptor memory of a USB device core and gives a host processor a small register window for filling it. The host first points the address register at a location. It then streams bytes through the data register. Every data access, whether a read or a write, moves the pointer forward by one, so a descriptor table can be loaded or read back with repeated accesses to a single register.

A control bit hands the memory to the device core. While the bit is clear, the host owns the memory. While it is set, host data accesses are locked out and the device core reads the memory through its own port, which has a one-cycle latency. The host register window decodes four offsets:

| Offset | Register |
|---|---|
| 0 | Control: bit 0 hands the memory to the core; other bits read 0 |
| 1 | Address: the 8-bit pointer |
| 2 | Data: one byte per access |
| 3 | Reads 0; writes have no effect |

Top module: `desc_ram_port`

## Requirements
- R1: After reset, the address register reads 0 and the control register reads 0, so the host owns the memory.
- R2: A host write to offset 1 loads the address pointer with the written byte, whatever the state of the control bit. The next data access uses that location.
- R3: While control bit 0 is clear, a host write to offset 2 stores the byte at the pointer location. The pointer then increases by one.
- R4: While control bit 0 is clear, a host read of offset 2 returns the byte at the pointer location in the same cycle (combinational read data). The pointer then increases by one.
- R5: The pointer is 8 bits wide and steps from 255 to 0.
- R6: While control bit 0 is set, a host write to offset 2 leaves the memory contents and the pointer unchanged.
- R7: While control bit 0 is set, a host read of offset 2 returns 0 and leaves the pointer unchanged.
- R8: When control bit 0 is set and `core_rd_en` is high, `core_rd_data` shows the byte at `core_addr` one cycle later. In the cycle after any cycle where that condition does not hold, `core_rd_data` is 0.
- R9: A host read of offset 1 returns the current pointer, including all automatic increments. A host read of offset 0 returns the control bit in bit 0 and zeros elsewhere. A read of offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Register offset: 0 control, 1 address, 2 data |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the access cycle |
| core_rd_en | input | 1 | Core-side read request |
| core_addr | input | 8 | Core-side read address |
| core_rd_data | output | 8 | Core-side read data, one cycle after the request |

## Verification
The hardest situation to reach is a locked-out data write. Its lack of effect only becomes visible after the host takes the memory back, points at the same location and reads the byte. The directed part of the bench does exactly that around location 255, so that the pointer wrap, the lockout and the read-back all meet at one address. Random stimulus then toggles the control bit between bursts of mixed accesses and core reads. A bench model checks every read.

// File: rtl/desc_ram_pkg.sv
package desc_ram_pkg;
    typedef enum logic [1:0] {
        OFF_CTRL = 2'd0,
        OFF_ADDR = 2'd1,
        OFF_DATA = 2'd2,
        OFF_NONE = 2'd3
    } reg_off_e;

    localparam int CTRL_OWN_BIT = 0;
endpackage

// File: rtl/desc_ram_store.sv
module desc_ram_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] core_d, core_q;

    // host read is combinational so the data register answers in the access cycle
    assign host_rdata = mem[host_addr];

    always_ff @(posedge clk) begin
        if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    always_comb begin
        core_d = '0;
        if (core_req) begin
            core_d = mem[core_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign core_rdata = core_q;
endmodule

// File: rtl/desc_ram_regs.sv
module desc_ram_regs
    import desc_ram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_off,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          core_own
);
    typedef struct packed {
        logic          own;
        logic [AW-1:0] addr;
    } state_t;

    state_t   st_d, st_q;
    reg_off_e off;
    logic     data_acc;

    assign off = reg_off_e'(bus_off);

    always_comb begin
        st_d      = st_q;
        data_acc  = bus_sel && (off == OFF_DATA) && !st_q.own;
        ram_we    = data_acc && bus_wr;
        bus_rdata = '0;
        if (bus_sel && bus_wr) begin
            unique case (off)
                OFF_CTRL: st_d.own  = bus_wdata[CTRL_OWN_BIT];
                OFF_ADDR: st_d.addr = bus_wdata[AW-1:0];
                default: ;
            endcase
        end
        if (bus_sel && !bus_wr) begin
            unique case (off)
                OFF_CTRL: bus_rdata[CTRL_OWN_BIT] = st_q.own;
                OFF_ADDR: bus_rdata[AW-1:0] = st_q.addr;
                OFF_DATA: bus_rdata = st_q.own ? '0 : ram_rdata;
                default: ;
            endcase
        end
        // pointer advances on any permitted data access; wraps naturally
        if (data_acc) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_addr = st_q.addr;
    assign core_own = st_q.own;
endmodule

// File: rtl/desc_ram_port.sv
module desc_ram_port #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_off,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          core_rd_en,
    input  logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_rd_data
);
    logic          ram_we;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] host_rd;
    logic          core_own;

    desc_ram_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_off   (bus_off),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ram_rdata (host_rd),
        .ram_we    (ram_we),
        .ram_addr  (cur_addr),
        .core_own  (core_own)
    );

    desc_ram_store #(.AW(AW), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (ram_we),
        .host_addr  (cur_addr),
        .host_wdata (bus_wdata),
        .host_rdata (host_rd),
        .core_req   (core_rd_en && core_own),
        .core_addr  (core_addr),
        .core_rdata (core_rd_data)
    );
endmodule

// File: rtl/desc_ram_port_chk.sv
module desc_ram_port_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [1:0]    bus_off,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          core_rd_en,
    input logic [DW-1:0] core_rd_data,
    input logic [AW-1:0] cur_addr,
    input logic          core_own,
    input logic          ram_we
);
    logic data_sel;
    assign data_sel = bus_sel && (bus_off == 2'd2);

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_off == 2'd1) |=> (cur_addr == $past(bus_wdata[AW-1:0]))); // R2

    AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && !core_own) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R3

    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        core_own |-> !ram_we); // R6

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && core_own) |=> $stable(cur_addr)); // R7

    AST_LOCK_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && !bus_wr && core_own) |-> (bus_rdata == '0)); // R7

    AST_CORE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rd_en && core_own) |=> (core_rd_data == '0)); // R8
endmodule

bind desc_ram_port desc_ram_port_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_off      (bus_off),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .core_rd_en   (core_rd_en),
    .core_rd_data (core_rd_data),
    .cur_addr     (cur_addr),
    .core_own     (core_own),
    .ram_we       (ram_we)
);

// File: tb/test_desc_ram_port.sv
module test_desc_ram_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_off = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       core_rd_en = 1'b0;
    logic [7:0] core_addr = 8'd0;
    logic [7:0] core_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [256];
    logic [7:0] m_addr;
    logic       m_own;

    always #2 clk = ~clk;

    desc_ram_port i_desc_ram_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_off      (bus_off),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .core_rd_en   (core_rd_en),
        .core_addr    (core_addr),
        .core_rd_data (core_rd_data)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] off);
        case (off)
            2'd0: return {7'd0, m_own};
            2'd1: return m_addr;
            2'd2: return m_own ? 8'd0 : m_mem[m_addr];
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_core(input logic en, input logic [7:0] a);
        return (en && m_own) ? m_mem[a] : 8'd0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        core_rd_en = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(posedge clk);
        case (off)
            2'd0: m_own = d[0];
            2'd1: m_addr = d;
            2'd2: if (!m_own) begin m_mem[m_addr] = d; m_addr = m_addr + 8'd1; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] off, input string tag);
        logic [7:0] e;
        @(negedge clk);
        core_rd_en = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off;
        e = exp_read(off);
        #1 check(tag, bus_rdata, e);
        @(posedge clk);
        if (off == 2'd2 && !m_own) m_addr = m_addr + 8'd1;
    endtask

    task automatic core_rd(input logic en, input logic [7:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        bus_sel = 1'b0;
        core_rd_en = en; core_addr = a;
        e = exp_core(en, a);
        @(negedge clk);
        core_rd_en = 1'b0;
        check(tag, core_rd_data, e);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_addr = 8'd0; m_own = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, "R1 addr after reset");
        rd(2'd0, "R1 ctrl after reset");

        // fill whole memory through auto-increment, R3
        for (int i = 0; i < 256; i++) wr(2'd2, 8'(i * 7 + 3));
        rd(2'd1, "R5 pointer wrapped to 0 after 256 writes");

        // R2 + R4 read back from a chosen location
        wr(2'd1, 8'd40);
        rd(2'd2, "R4 read at 40");
        rd(2'd2, "R4 read at 41");
        rd(2'd1, "R9 pointer after two reads");

        // R5 wrap on a read and a write
        wr(2'd1, 8'd255);
        rd(2'd2, "R5 read at 255");
        rd(2'd1, "R5 pointer wraps to 0");
        wr(2'd1, 8'd255);
        wr(2'd2, 8'hA5);
        rd(2'd1, "R5 pointer wraps after write");

        // R6 R7 lockout, then read back location 255
        wr(2'd1, 8'd255);
        wr(2'd0, 8'd1);
        rd(2'd0, "R9 ctrl reads own bit");
        wr(2'd2, 8'h3C);
        rd(2'd1, "R6 pointer held on locked write");
        rd(2'd2, "R7 locked read returns zero");
        rd(2'd1, "R7 pointer held on locked read");
        wr(2'd1, 8'd10);
        rd(2'd1, "R2 address write while locked");
        core_rd(1'b1, 8'd255, "R8 core read at 255");
        core_rd(1'b1, 8'd41, "R8 core read at 41");
        core_rd(1'b0, 8'd41, "R8 core idle gives zero");
        wr(2'd0, 8'd0);
        core_rd(1'b1, 8'd41, "R8 core read while host owns gives zero");
        wr(2'd1, 8'd255);
        rd(2'd2, "R6 locked write left byte 255 intact");
        rd(2'd3, "R9 unused offset reads zero");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned p;
            p = $urandom_range(0, 99);
            if (p < 4) wr(2'd0, 8'($urandom_range(0, 1)));
            else if (p < 12) wr(2'd1, 8'($urandom_range(0, 255)));
            else if (p < 40) wr(2'd2, 8'($urandom_range(0, 255)));
            else if (p < 65) rd(2'd2, "R3 R4 R6 R7 random data read");
            else if (p < 72) rd(2'd1, "R9 random address read");
            else if (p < 75) rd(2'd0, "R9 random ctrl read");
            else if (p < 77) wr(2'd3, 8'($urandom_range(0, 255)));
            else core_rd(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), "R8 random core read");
        end

        @(negedge clk);
        bus_sel = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule